// File: doc/BRIEF.md
# Vector Floating-Point Exception Screen and Status Register

This block sits beside a single-precision vector arithmetic unit. Each lane operation issued to the unit also arrives here, as an operation class code and the two 32-bit source operands. The block screens both operands for invalid (signaling NaN), denormal-operand and divide-by-zero conditions. It also takes an overflow indication from the arithmetic datapath. Which of these conditions may be raised depends on the operation class.

When the denormals-are-zero control is on, the block hands the datapath conditioned operands: any denormal is replaced by a zero of the same sign. The zero and finiteness tests for divide-by-zero are made on these conditioned values. The denormal test is always made on the original operand.

The raised conditions are shown per operation. They also accumulate as sticky flags in a 32-bit control/status register that software can read and write. A one-cycle request goes out whenever an operation raises a condition whose mask bit is clear.

Top module: `simd_fpx_status`

## Requirements
- R1: After reset the register reads 0x0000_0780: all four flags are 0, all four masks (bits 7..10) are 1, and the denormals-are-zero (bit 6) and flush-to-zero (bit 15) controls are 0. `unmask_req` is 0.
- R2: `exc_flags[0]` (invalid) is 1 when either operand is a signaling NaN, meaning exponent all ones, fraction nonzero and fraction MSB clear. It is raised for every class except the reciprocal estimate (class 7). A quiet NaN raises nothing.
- R3: `exc_flags[1]` (denormal) is 1 when either original operand has a zero exponent and a nonzero fraction. It is raised for every class except narrowing convert (5), other convert (6) and reciprocal estimate (7), and it is raised even when bit 6 is set.
- R4: When bit 6 is 1, each denormal operand appears on `cond_a`/`cond_b` as a zero with its sign kept. Every other operand, and every operand when bit 6 is 0, passes through unchanged.
- R5: `exc_flags[2]` (divide-by-zero) is 1 only for the divide class (3), when the conditioned dividend `a` is finite and non-zero and the conditioned divisor `b` is zero.
- R6: `exc_flags[3]` (overflow) equals `dp_ovf` for classes add (0), subtract (1), multiply (2), divide (3), horizontal/alternating add-subtract (4) and narrowing convert (5). It is 0 for all other classes; codes 8..15 are compare-like classes.
- R7: At the clock edge that ends a valid operation, its `exc_flags` are ORed into register bits 0..3. A flag stays set until a software write clears it.
- R8: A write loads bits 0..3, 6, 7..10 and 15 from `csr_wdata`; all other bits read 0. When a write and an operation fall in the same cycle, the operation's flags are ORed on top of the written value.
- R9: `unmask_req` is 1 for exactly the cycle after a valid operation that raises any flag n whose mask bit n+7, as held in the register during that operation, is 0. Otherwise it is 0.
- R10: The flush-to-zero control (bit 15) has no effect on any detected condition or conditioned operand.
- R11: `exc_flags` is 0 in any cycle in which `op_valid` is 0, and the register flags do not change in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_class | input | 4 | Operation class code |
| opnd_a | input | 32 | First source operand (dividend) |
| opnd_b | input | 32 | Second source operand (divisor) |
| dp_ovf | input | 1 | Datapath reports rounded result beyond largest finite |
| csr_we | input | 1 | Software register write strobe |
| csr_wdata | input | 32 | Software register write data |
| cond_a | output | 32 | First operand after denormals-are-zero conditioning |
| cond_b | output | 32 | Second operand after denormals-are-zero conditioning |
| exc_flags | output | 4 | Conditions raised by this operation {ovf, divz, den, inv} |
| csr_rdata | output | 32 | Register contents |
| unmask_req | output | 1 | One-cycle request for an unmasked raised condition |

## Verification
A wrong classification shows on `exc_flags` in the same cycle as the operation. It reaches `csr_rdata` one edge later and stays there, because the flags are sticky. A lost or spurious flag therefore remains visible until the next software write. A stale or misread mask shows as a missing or extra `unmask_req` pulse in the cycle after the operation. A wrong conditioning path shows at once on `cond_a`/`cond_b`, and also as a wrong divide-by-zero decision when a denormal divisor or dividend is involved.

// File: rtl/simd_fpx_pkg.sv
package simd_fpx_pkg;

  typedef enum logic [3:0] {
    OPC_ADD     = 4'd0,
    OPC_SUB     = 4'd1,
    OPC_MUL     = 4'd2,
    OPC_DIV     = 4'd3,
    OPC_HADDSUB = 4'd4,
    OPC_CVT_NAR = 4'd5,
    OPC_CVT_OTH = 4'd6,
    OPC_RCP     = 4'd7,
    OPC_CMP     = 4'd8
  } op_class_e;

  localparam int CSR_W     = 32;
  localparam int NFLAG     = 4;
  localparam int FLAG_LSB  = 0;
  localparam int DAZ_BIT   = 6;
  localparam int MASK_LSB  = 7;
  localparam int FTZ_BIT   = 15;

  localparam logic [CSR_W-1:0] CSR_WMASK =
    (CSR_W'((1 << NFLAG) - 1) << FLAG_LSB) |
    (CSR_W'((1 << NFLAG) - 1) << MASK_LSB) |
    (CSR_W'(1) << DAZ_BIT) | (CSR_W'(1) << FTZ_BIT);

  localparam logic [CSR_W-1:0] CSR_RESET = CSR_W'((1 << NFLAG) - 1) << MASK_LSB;

  // class capability helpers
  function automatic logic cls_may_den(input op_class_e c);
    return !(c inside {OPC_CVT_NAR, OPC_CVT_OTH, OPC_RCP});
  endfunction

  function automatic logic cls_may_ovf(input op_class_e c);
    return c inside {OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV, OPC_HADDSUB, OPC_CVT_NAR};
  endfunction

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DW    = 1 + EXP_W + FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opnd,
  input  logic          daz_en,
  output logic [DW-1:0] cond,
  output logic          is_den,
  output logic          is_snan,
  output logic          c_zero,
  output logic          c_finite
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = opnd[DW-2 -: EXP_W];
  assign frac_f = opnd[FRAC_W-1:0];

  assign is_den   = (exp_f == '0) && (frac_f != '0);
  assign is_snan  = (exp_f == '1) && (frac_f != '0) && !frac_f[FRAC_W-1];
  assign cond     = (daz_en && is_den) ? {opnd[DW-1], {(DW-1){1'b0}}} : opnd;
  assign c_zero   = (cond[DW-2:0] == '0);
  assign c_finite = (cond[DW-2 -: EXP_W] != '1);

  AST_DAZ_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cond[DW-1] == opnd[DW-1]); // R4
  AST_DAZ_CLEARS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (daz_en && is_den) |-> c_zero); // R4

endmodule

// File: rtl/fpx_detect.sv
module fpx_detect
  import simd_fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  op_class_e        cls,
  input  logic             a_den,
  input  logic             b_den,
  input  logic             a_snan,
  input  logic             b_snan,
  input  logic             a_zero,
  input  logic             a_finite,
  input  logic             b_zero,
  input  logic             ovf_in,
  output logic [NFLAG-1:0] flags
);
  logic raise_inv, raise_den, raise_divz, raise_ovf;

  assign raise_inv  = (cls != OPC_RCP) && (a_snan || b_snan);
  assign raise_den  = cls_may_den(cls) && (a_den || b_den);
  assign raise_divz = (cls == OPC_DIV) && a_finite && !a_zero && b_zero;
  assign raise_ovf  = cls_may_ovf(cls) && ovf_in;

  assign flags = valid ? {raise_ovf, raise_divz, raise_den, raise_inv} : '0;

  AST_RCP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == OPC_RCP) |-> (flags == '0)); // R2
  AST_CVT_NO_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cls inside {OPC_CVT_NAR, OPC_CVT_OTH}) |-> !flags[1]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_in |-> !flags[3]); // R6
  AST_DIVZ_ONLY_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> (cls == OPC_DIV)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (flags == '0)); // R11

endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import simd_fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             valid,
  input  logic [NFLAG-1:0] flags,
  output logic [CSR_W-1:0] csr,
  output logic             daz_en,
  output logic             req
);
  logic [CSR_W-1:0] reg_q, reg_d;
  logic [NFLAG-1:0] masks;
  logic             req_d;

  assign masks = reg_q[MASK_LSB +: NFLAG];
  assign req_d = valid && ((flags & ~masks) != '0);

  always_comb begin
    reg_d = we ? (wdata & CSR_WMASK) : reg_q;
    reg_d[FLAG_LSB +: NFLAG] = reg_d[FLAG_LSB +: NFLAG] | flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= CSR_RESET;
      req   <= 1'b0;
    end else begin
      reg_q <= reg_d;
      req   <= req_d;
    end
  end

  assign csr    = reg_q;
  assign daz_en = reg_q[DAZ_BIT];

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> ((reg_q[FLAG_LSB +: NFLAG] & $past(reg_q[FLAG_LSB +: NFLAG]))
                    == $past(reg_q[FLAG_LSB +: NFLAG]))); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q & ~CSR_WMASK) == '0); // R8
  AST_REQ_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(valid)); // R9

endmodule

// File: rtl/simd_fpx_status.sv
module simd_fpx_status
  import simd_fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_class,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic        dp_ovf,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] cond_a,
  output logic [31:0] cond_b,
  output logic [3:0]  exc_flags,
  output logic [31:0] csr_rdata,
  output logic        unmask_req
);
  op_class_e  cls;
  logic       daz_en;
  logic       a_den, a_snan, a_zero, a_finite;
  logic       b_den, b_snan, b_zero, b_finite;
  logic [NFLAG-1:0] flags;

  assign cls = op_class_e'(op_class);

  fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .clk(clk), .rst_n(rst_n), .opnd(opnd_a), .daz_en(daz_en), .cond(cond_a),
    .is_den(a_den), .is_snan(a_snan), .c_zero(a_zero), .c_finite(a_finite));

  fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .clk(clk), .rst_n(rst_n), .opnd(opnd_b), .daz_en(daz_en), .cond(cond_b),
    .is_den(b_den), .is_snan(b_snan), .c_zero(b_zero), .c_finite(b_finite));

  fpx_detect u_det (
    .clk(clk), .rst_n(rst_n), .valid(op_valid), .cls(cls),
    .a_den(a_den), .b_den(b_den), .a_snan(a_snan), .b_snan(b_snan),
    .a_zero(a_zero), .a_finite(a_finite), .b_zero(b_zero),
    .ovf_in(dp_ovf), .flags(flags));

  fpx_csr u_csr (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
    .valid(op_valid), .flags(flags), .csr(csr_rdata),
    .daz_en(daz_en), .req(unmask_req));

  assign exc_flags = flags;

  AST_DEN_SEEN_UNDER_DAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && a_den && cls == OPC_ADD) |-> exc_flags[1]); // R3
  AST_FINITE_B_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flags[2]) |-> b_finite); // R5

endmodule

// File: tb/simd_fpx_status_tb.sv
module simd_fpx_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_class = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        dp_ovf = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] cond_a, cond_b, csr_rdata;
  logic [3:0]  exc_flags;
  logic        unmask_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_csr;
  logic        m_req;

  always #2 clk = ~clk;

  simd_fpx_status dut_i (.*);

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  // operand kinds: 0 one, 1 +0, 2 -0, 3 +den, 4 -den, 5 snan, 6 qnan, 7 inf
  function automatic logic [31:0] kval(input int k);
    case (k)
      0: return 32'h3F80_0000; 1: return 32'h0000_0000; 2: return 32'h8000_0000;
      3: return 32'h0000_0123; 4: return 32'h8040_0000; 5: return 32'h7F80_0001;
      6: return 32'h7FC0_0000; default: return 32'h7F80_0000;
    endcase
  endfunction

  function automatic logic [31:0] kcond(input int k, input logic daz);
    if (daz && k == 3) return 32'h0;
    if (daz && k == 4) return 32'h8000_0000;
    return kval(k);
  endfunction

  function automatic logic [3:0] kflags(input int c, input int a, input int b,
                                        input logic daz, input logic ov);
    logic inv, den, dz, of, a_fnz, b_z;
    inv = (c != 7) && (a == 5 || b == 5);
    den = !(c inside {5, 6, 7}) && (a inside {3, 4} || b inside {3, 4});
    a_fnz = (a == 0) || (!daz && a inside {3, 4});
    b_z = (b inside {1, 2}) || (daz && b inside {3, 4});
    dz = (c == 3) && a_fnz && b_z;
    of = (c <= 5) && ov;
    return {of, dz, den, inv};
  endfunction

  task automatic cycle(input logic v, input int c, input int a, input int b,
                       input logic ov, input logic we, input logic [31:0] wd, input string rq);
    logic [3:0] ef;
    logic daz;
    @(negedge clk);
    op_valid = v; op_class = 4'(c); opnd_a = kval(a); opnd_b = kval(b);
    dp_ovf = ov; csr_we = we; csr_wdata = wd;
    daz = m_csr[6];
    ef = v ? kflags(c, a, b, daz, ov) : 4'h0;
    #1;
    chk(v ? "R2/R3/R5/R6 flags" : "R11 idle flags", {28'h0, exc_flags}, {28'h0, ef});
    if (v) begin
      chk("R4 cond_a", cond_a, kcond(a, daz));
      chk("R4 cond_b", cond_b, kcond(b, daz));
    end
    m_req = v && ((ef & ~m_csr[10:7]) != 0);
    if (we) m_csr = wd & 32'h0000_87CF;
    m_csr[3:0] = m_csr[3:0] | ef;
    @(posedge clk); #1;
    chk({rq, " R7/R8 csr"}, csr_rdata, m_csr);
    chk("R9 unmask_req", {31'h0, unmask_req}, {31'h0, m_req});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_csr = 32'h0000_0780;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset csr", csr_rdata, 32'h0000_0780);
    chk("R1 reset req", {31'h0, unmask_req}, 32'h0);

    // R8: writable bits and reserved zeros
    cycle(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R8 write all");
    cycle(0, 0, 0, 0, 0, 1, 32'h0000_0780, "R8 restore");
    // R11: idle cycle with exception-looking inputs changes nothing
    cycle(0, 3, 0, 1, 1, 0, 0, "R11 idle");
    // R8: write in same cycle as an op, flag ORed on top
    cycle(1, 0, 5, 0, 0, 1, 32'h0000_0000, "R8 write+op");
    // R7: benign op keeps sticky flag
    cycle(1, 0, 0, 0, 0, 0, 0, "R7 sticky");

    // near-exhaustive sweep; R10 via ftz loop
    for (int ftz = 0; ftz < 2; ftz++)
      for (int daz = 0; daz < 2; daz++)
        for (int c = 0; c < 10; c++) begin
          cycle(0, 0, 0, 0, 0, 1,
                (32'(ftz) << 15) | (32'(daz) << 6) | (32'((c * 5 + daz + ftz) & 15) << 7),
                "R10 setup");
          for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
              for (int ov = 0; ov < 2; ov++)
                cycle(1, c, a, b, 1'(ov), 0, 0, "sweep");
        end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule